// File: doc/BRIEF.md
# Commit-Driven Taint Instruction Generator

This block sits at the retirement point of a two-context multithreaded core. Each instruction that the primary thread retires is looked up by its opcode in a 64-entry translation table. That lookup yields a security opcode and a class: arithmetic, load, store or system call. The generator then builds at most one taint-tracking instruction. The instruction carries the translated opcode and the original destination and source register numbers, and it is queued for the second hardware context. The effective address of every emitted load or store goes into a parallel address queue, in the same order.

A filter drops every instruction that cannot change taint state. The filter reads a speculative register taint vector and the page taint bit that the TLB reports with the retiring instruction. Retired arithmetic and load instructions update the vector, so later filter decisions stay consistent with the work already queued. When a queue has no room for what a retirement would produce, the block holds retirement back. A system call is held until both queues have drained, which keeps the two threads in step.

Top module: `tig_gen`

## Requirements
- R1: After reset both queues are empty (`ins_valid` and `addr_valid` low), the taint vector is all clean, and every table entry is invalid, so `commit_ready` is high and a retirement produces nothing.
- R2: An emitted instruction carries the security opcode of the table entry selected by `commit_opc`, together with the retired instruction's `commit_rd`, `commit_rs1` and `commit_rs2` unchanged. A table entry is written through `tbl_wr_*` and holds a valid flag, a class (0 arithmetic, 1 load, 2 store, 3 system call) and a security opcode.
- R3: A retirement whose table entry is invalid is always accepted, emits nothing, pushes no address and leaves the taint vector unchanged.
- R4: An arithmetic retirement emits only when taint(rd) differs from taint(rs1) OR taint(rs2). On acceptance taint(rd) becomes taint(rs1) OR taint(rs2).
- R5: A load emits unless both the page taint and taint(rd) are clean. On acceptance taint(rd) becomes the page taint.
- R6: A store emits unless both the page taint and taint(rs2), the data register, are clean. A store never changes the taint vector.
- R7: Every emitted load or store pushes its `commit_addr` into the address queue. Arithmetic and filtered retirements push no address.
- R8: `commit_ready` is low only when the retirement would push into a full queue. A retirement that is filtered out is accepted even while the queues are full.
- R9: A system-call retirement emits nothing and is accepted only while both queues are empty.
- R10: Each queue delivers its entries in push order. An entry stays at the head, stable, until it is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tbl_wr_en | input | 1 | Write strobe for the translation table |
| tbl_wr_idx | input | 6 | Table entry to write (primary opcode) |
| tbl_wr_valid | input | 1 | Valid flag of the written entry |
| tbl_wr_kind | input | 2 | Class: 0 arithmetic, 1 load, 2 store, 3 system call |
| tbl_wr_sop | input | 6 | Security opcode of the written entry |
| commit_valid | input | 1 | A primary-thread instruction retires this cycle |
| commit_ready | output | 1 | Retirement accepted; low holds retirement back |
| commit_opc | input | 6 | Primary opcode of the retiring instruction |
| commit_rd | input | 5 | Destination register |
| commit_rs1 | input | 5 | First source / base register |
| commit_rs2 | input | 5 | Second source / store data register |
| commit_addr | input | ADDR_W | Effective address of a load or store |
| commit_page_taint | input | 1 | TLB taint bit of the accessed page |
| ins_valid | output | 1 | Instruction queue holds an entry |
| ins_pop | input | 1 | Remove the head of the instruction queue |
| ins_sop | output | 6 | Head entry security opcode |
| ins_rd | output | 5 | Head entry destination register |
| ins_rs1 | output | 5 | Head entry first source |
| ins_rs2 | output | 5 | Head entry second source |
| addr_valid | output | 1 | Address queue holds an entry |
| addr_pop | input | 1 | Remove the head of the address queue |
| addr_data | output | ADDR_W | Head address |

## Verification
All eight taint combinations of destination and two sources are driven through arithmetic retirement. The four combinations of page and register taint are driven through loads and stores. Together these separate the three filter rules from one another and from a filter that always or never emits. Taint is brought into registers only by tainted-page loads, so a wrong vector update shows up as a wrong emission decision later on. The queues are filled to capacity to check that only retirements needing space are held, and a system call is retired against full queues and then against empty ones.

// File: rtl/tig_pkg.sv
package tig_pkg;
    localparam int OPC_W = 6;
    localparam int REG_W = 5;
    localparam int SOP_W = 6;

    typedef enum logic [1:0] {
        K_ALU   = 2'd0,
        K_LOAD  = 2'd1,
        K_STORE = 2'd2,
        K_SYS   = 2'd3
    } kind_e;

    typedef struct packed {
        logic             ok;
        kind_e            kind;
        logic [SOP_W-1:0] sop;
    } xlat_t;

    typedef struct packed {
        logic [SOP_W-1:0] sop;
        logic [REG_W-1:0] rd;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rs2;
    } tinst_t;

    localparam int TINST_W = $bits(tinst_t);

    // Decide whether a retired instruction can alter taint state.
    function automatic logic can_change(kind_e k, logic td, logic t1, logic t2, logic pg);
        case (k)
            K_ALU:   can_change = (td != (t1 | t2));
            K_LOAD:  can_change = pg | td;
            K_STORE: can_change = pg | t2;
            default: can_change = 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/tig_opc_table.sv
module tig_opc_table import tig_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [OPC_W-1:0] wr_idx,
    input  xlat_t            wr_ent,
    input  logic [OPC_W-1:0] rd_idx,
    output xlat_t            rd_ent
);
    localparam int ENTRIES = 2 ** OPC_W;

    xlat_t tbl [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < ENTRIES; i++) tbl[i] <= '0;
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_ent;
        end
    end

    assign rd_ent = tbl[rd_idx];
endmodule

// File: rtl/tig_taint_vec.sv
module tig_taint_vec import tig_pkg::*; (
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] rd_idx,
    input  logic [REG_W-1:0] rs1_idx,
    input  logic [REG_W-1:0] rs2_idx,
    output logic             t_rd,
    output logic             t_rs1,
    output logic             t_rs2,
    input  logic             upd_en,
    input  logic             upd_val
);
    localparam int NREG = 2 ** REG_W;

    logic [NREG-1:0] tv;

    always_ff @(posedge clk) begin
        if (rst)         tv <= '0;
        else if (upd_en) tv[rd_idx] <= upd_val;
    end

    assign t_rd  = tv[rd_idx];
    assign t_rs1 = tv[rs1_idx];
    assign t_rs2 = tv[rs2_idx];
endmodule

// File: rtl/tig_fifo.sv
module tig_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         valid,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign valid   = (cnt != '0);
    assign do_push = push && !full;
    assign do_pop  = pop && valid;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end
endmodule

// File: rtl/tig_gen.sv
module tig_gen import tig_pkg::*; #(
    parameter int ADDR_W   = 32,
    parameter int IQ_DEPTH = 4,
    parameter int AQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tbl_wr_en,
    input  logic [OPC_W-1:0]  tbl_wr_idx,
    input  logic              tbl_wr_valid,
    input  logic [1:0]        tbl_wr_kind,
    input  logic [SOP_W-1:0]  tbl_wr_sop,
    input  logic              commit_valid,
    output logic              commit_ready,
    input  logic [OPC_W-1:0]  commit_opc,
    input  logic [REG_W-1:0]  commit_rd,
    input  logic [REG_W-1:0]  commit_rs1,
    input  logic [REG_W-1:0]  commit_rs2,
    input  logic [ADDR_W-1:0] commit_addr,
    input  logic              commit_page_taint,
    output logic              ins_valid,
    input  logic              ins_pop,
    output logic [SOP_W-1:0]  ins_sop,
    output logic [REG_W-1:0]  ins_rd,
    output logic [REG_W-1:0]  ins_rs1,
    output logic [REG_W-1:0]  ins_rs2,
    output logic              addr_valid,
    input  logic              addr_pop,
    output logic [ADDR_W-1:0] addr_data
);
    xlat_t  wr_ent, ent;
    tinst_t push_ins, head_ins;
    logic   t_rd, t_rs1, t_rs2;
    logic   ent_ok, is_sys, is_mem, is_alu, is_load;
    logic   emit, need_addr, accept;
    logic   ins_push, addr_push, iq_full, aq_full;
    logic   upd_en, upd_val;

    assign wr_ent = '{ok: tbl_wr_valid, kind: kind_e'(tbl_wr_kind), sop: tbl_wr_sop};

    tig_opc_table u_tbl (
        .clk(clk), .rst(rst),
        .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_ent(wr_ent),
        .rd_idx(commit_opc), .rd_ent(ent)
    );

    tig_taint_vec u_tv (
        .clk(clk), .rst(rst),
        .rd_idx(commit_rd), .rs1_idx(commit_rs1), .rs2_idx(commit_rs2),
        .t_rd(t_rd), .t_rs1(t_rs1), .t_rs2(t_rs2),
        .upd_en(upd_en), .upd_val(upd_val)
    );

    assign ent_ok  = ent.ok;
    assign is_sys  = ent.ok && (ent.kind == K_SYS);
    assign is_alu  = ent.ok && (ent.kind == K_ALU);
    assign is_load = ent.ok && (ent.kind == K_LOAD);
    assign is_mem  = ent.ok && ((ent.kind == K_LOAD) || (ent.kind == K_STORE));

    assign emit      = ent.ok && can_change(ent.kind, t_rd, t_rs1, t_rs2, commit_page_taint);
    assign need_addr = emit && is_mem;

    always_comb begin
        if (!ent.ok)    commit_ready = 1'b1;
        else if (is_sys) commit_ready = !ins_valid && !addr_valid;
        else            commit_ready = !(emit && iq_full) && !(need_addr && aq_full);
    end

    assign accept    = commit_valid && commit_ready;
    assign ins_push  = accept && emit;
    assign addr_push = accept && need_addr;
    assign upd_en    = accept && (is_alu || is_load);
    assign upd_val   = is_load ? commit_page_taint : (t_rs1 | t_rs2);

    assign push_ins = '{sop: ent.sop, rd: commit_rd, rs1: commit_rs1, rs2: commit_rs2};

    tig_fifo #(.W(TINST_W), .DEPTH(IQ_DEPTH)) u_iq (
        .clk(clk), .rst(rst),
        .push(ins_push), .din(push_ins),
        .pop(ins_pop), .dout(head_ins), .valid(ins_valid), .full(iq_full)
    );

    tig_fifo #(.W(ADDR_W), .DEPTH(AQ_DEPTH)) u_aq (
        .clk(clk), .rst(rst),
        .push(addr_push), .din(commit_addr),
        .pop(addr_pop), .dout(addr_data), .valid(addr_valid), .full(aq_full)
    );

    assign ins_sop = head_ins.sop;
    assign ins_rd  = head_ins.rd;
    assign ins_rs1 = head_ins.rs1;
    assign ins_rs2 = head_ins.rs2;
endmodule

// File: rtl/tig_gen_chk.sv
module tig_gen_chk (
    input logic clk,
    input logic rst,
    input logic commit_valid,
    input logic commit_ready,
    input logic ent_ok,
    input logic is_sys,
    input logic is_mem,
    input logic ins_push,
    input logic addr_push,
    input logic iq_full,
    input logic aq_full,
    input logic ins_valid,
    input logic ins_pop,
    input logic addr_valid,
    input logic addr_pop,
    input logic [20:0] head_ins
);
    // R3
    invalid_entry_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && !ent_ok) |-> (commit_ready && !ins_push && !addr_push));

    // R7
    mem_addr_pair_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_push && is_mem) |-> addr_push);

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        !(ins_push && iq_full) && !(addr_push && aq_full));

    // R9
    sys_drained_chk: assert property (@(posedge clk) disable iff (rst)
        (commit_valid && commit_ready && is_sys) |-> (!ins_valid && !addr_valid && !ins_push));

    // R10
    head_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !ins_pop) |=> (ins_valid && $stable(head_ins)));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (addr_valid && !addr_pop) |=> addr_valid);
endmodule

bind tig_gen tig_gen_chk u_chk (
    .clk(clk), .rst(rst),
    .commit_valid(commit_valid), .commit_ready(commit_ready),
    .ent_ok(ent_ok), .is_sys(is_sys), .is_mem(is_mem),
    .ins_push(ins_push), .addr_push(addr_push),
    .iq_full(iq_full), .aq_full(aq_full),
    .ins_valid(ins_valid), .ins_pop(ins_pop),
    .addr_valid(addr_valid), .addr_pop(addr_pop),
    .head_ins(head_ins)
);

// File: tb/tig_gen_tb_top.sv
module tig_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int IQD = 4;
    localparam int AQD = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tbl_wr_en = 1'b0, tbl_wr_valid = 1'b0;
    logic [5:0]  tbl_wr_idx = '0, tbl_wr_sop = '0;
    logic [1:0]  tbl_wr_kind = '0;
    logic        commit_valid = 1'b0, commit_ready;
    logic [5:0]  commit_opc = '0;
    logic [4:0]  commit_rd = '0, commit_rs1 = '0, commit_rs2 = '0;
    logic [31:0] commit_addr = '0;
    logic        commit_page_taint = 1'b0;
    logic        ins_valid, ins_pop = 1'b0;
    logic [5:0]  ins_sop;
    logic [4:0]  ins_rd, ins_rs1, ins_rs2;
    logic        addr_valid, addr_pop = 1'b0;
    logic [31:0] addr_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // bench model
    logic        m_ok [64];
    logic [1:0]  m_kind [64];
    logic [5:0]  m_sop [64];
    logic [31:0] m_tv;
    logic [20:0] exp_i [$];
    logic [31:0] exp_a [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    tig_gen #(.ADDR_W(32), .IQ_DEPTH(IQD), .AQ_DEPTH(AQD)) dut_i (
        .clk(clk), .rst(rst),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_valid(tbl_wr_valid),
        .tbl_wr_kind(tbl_wr_kind), .tbl_wr_sop(tbl_wr_sop),
        .commit_valid(commit_valid), .commit_ready(commit_ready),
        .commit_opc(commit_opc), .commit_rd(commit_rd), .commit_rs1(commit_rs1),
        .commit_rs2(commit_rs2), .commit_addr(commit_addr),
        .commit_page_taint(commit_page_taint),
        .ins_valid(ins_valid), .ins_pop(ins_pop), .ins_sop(ins_sop),
        .ins_rd(ins_rd), .ins_rs1(ins_rs1), .ins_rs2(ins_rs2),
        .addr_valid(addr_valid), .addr_pop(addr_pop), .addr_data(addr_data)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tbl_write(input [5:0] idx, input logic ok, input [1:0] kind, input [5:0] sop);
        @(negedge clk);
        tbl_wr_en = 1'b1; tbl_wr_idx = idx; tbl_wr_valid = ok;
        tbl_wr_kind = kind; tbl_wr_sop = sop;
        @(posedge clk); #1;
        tbl_wr_en = 1'b0;
        m_ok[idx] = ok; m_kind[idx] = kind; m_sop[idx] = sop;
    endtask

    task automatic commit(input [5:0] opc, input [4:0] rd, input [4:0] rs1, input [4:0] rs2,
                          input [31:0] a, input logic pg, input string tag);
        logic e, r, mem, td, t1, t2;
        @(negedge clk);
        commit_valid = 1'b1; commit_opc = opc; commit_rd = rd; commit_rs1 = rs1;
        commit_rs2 = rs2; commit_addr = a; commit_page_taint = pg;
        #1;
        td = m_tv[rd]; t1 = m_tv[rs1]; t2 = m_tv[rs2];
        e = 1'b0; mem = 1'b0; r = 1'b1;
        if (m_ok[opc]) begin
            case (m_kind[opc])
                2'd0: e = (td != (t1 | t2));
                2'd1: begin e = pg | td; mem = 1'b1; end
                2'd2: begin e = pg | t2; mem = 1'b1; end
                default: e = 1'b0;
            endcase
            if (m_kind[opc] == 2'd3) r = (exp_i.size() == 0) && (exp_a.size() == 0);
            else r = !(e && exp_i.size() >= IQD) && !(e && mem && exp_a.size() >= AQD);
        end
        check(commit_ready == r, tag, 64'(commit_ready), 64'(r));
        @(posedge clk);
        if (r) begin
            if (e) exp_i.push_back({m_sop[opc], rd, rs1, rs2});
            if (e && mem) exp_a.push_back(a);
            if (m_ok[opc] && m_kind[opc] == 2'd0) m_tv[rd] = t1 | t2;
            if (m_ok[opc] && m_kind[opc] == 2'd1) m_tv[rd] = pg;
        end
        #1;
        commit_valid = 1'b0;
    endtask

    task automatic drain(input string tag);
        while (exp_i.size() > 0) begin
            @(negedge clk);
            check(ins_valid && ({ins_sop, ins_rd, ins_rs1, ins_rs2} == exp_i[0]), tag,
                  {42'(ins_valid), ins_sop, ins_rd, ins_rs1, ins_rs2}, {42'(1), exp_i[0]});
            ins_pop = 1'b1;
            @(posedge clk); #1;
            ins_pop = 1'b0;
            void'(exp_i.pop_front());
        end
        while (exp_a.size() > 0) begin
            @(negedge clk);
            check(addr_valid && (addr_data == exp_a[0]), {tag, "/R7"},
                  {31'(addr_valid), addr_data}, {31'(1), exp_a[0]});
            addr_pop = 1'b1;
            @(posedge clk); #1;
            addr_pop = 1'b0;
            void'(exp_a.pop_front());
        end
        @(negedge clk);
        check(!ins_valid && !addr_valid, {tag, "/R10 empty"}, {ins_valid, addr_valid}, 0);
    endtask

    initial begin : watchdog
        int cyc;
        cyc = 0;
        while (!done && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) begin
            m_ok[i] = 1'b0; m_kind[i] = 2'd0; m_sop[i] = 6'd0;
        end
        m_tv = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        @(negedge clk);
        check(!ins_valid && !addr_valid, "R1 queues empty", {ins_valid, addr_valid}, 0);
        check(commit_ready, "R1 ready", 64'(commit_ready), 1);
        commit(6'd2, 5'd1, 5'd0, 5'd0, 32'h10, 1'b1, "R1 empty table");
        drain("R1 nothing emitted");

        // table setup (R2)
        tbl_write(6'd1, 1'b1, 2'd0, 6'h21);
        tbl_write(6'd2, 1'b1, 2'd1, 6'h22);
        tbl_write(6'd3, 1'b1, 2'd2, 6'h23);
        tbl_write(6'd4, 1'b1, 2'd3, 6'h00);
        tbl_write(6'd5, 1'b0, 2'd0, 6'h3f);

        // R4 / R2: all source/destination taint combinations
        for (int c = 0; c < 8; c++) begin
            commit(6'd2, 5'd1, 5'd9, 5'd0, 32'h100 + 32'(c), c[0], "R5 setup");
            commit(6'd2, 5'd2, 5'd9, 5'd0, 32'h200 + 32'(c), c[1], "R5 setup");
            commit(6'd2, 5'd3, 5'd9, 5'd0, 32'h300 + 32'(c), c[2], "R5 setup");
            drain("R5 setup drain");
            commit(6'd1, 5'd3, 5'd1, 5'd2, 32'h0, 1'b0, "R4 alu");
            drain("R4/R2 alu emit");
            // the updated destination feeds the next decision
            commit(6'd1, 5'd4, 5'd3, 5'd3, 32'h0, 1'b0, "R4 alu chain");
            drain("R4 chained update");
        end

        // R5: load page/destination combinations
        for (int c = 0; c < 4; c++) begin
            commit(6'd2, 5'd6, 5'd9, 5'd0, 32'h400 + 32'(c), c[0], "R5 setup");
            drain("R5 setup drain");
            commit(6'd2, 5'd6, 5'd7, 5'd0, 32'h500 + 32'(c), c[1], "R5 load");
            drain("R5 load filter");
            commit(6'd1, 5'd8, 5'd6, 5'd6, 32'h0, 1'b0, "R5 load update");
            drain("R5 load update");
        end

        // R6: store page/data combinations
        for (int c = 0; c < 4; c++) begin
            commit(6'd2, 5'd10, 5'd9, 5'd0, 32'h600 + 32'(c), c[0], "R6 setup");
            drain("R6 setup drain");
            commit(6'd3, 5'd11, 5'd12, 5'd10, 32'h700 + 32'(c), c[1], "R6 store");
            drain("R6 store filter");
            commit(6'd1, 5'd11, 5'd11, 5'd11, 32'h0, 1'b0, "R6 no update");
            drain("R6 no update");
        end

        // R3: invalid entry with tainted sources
        commit(6'd2, 5'd13, 5'd9, 5'd0, 32'h800, 1'b1, "R3 setup");
        drain("R3 setup drain");
        commit(6'd5, 5'd14, 5'd13, 5'd13, 32'h900, 1'b1, "R3 invalid");
        drain("R3 nothing emitted");
        commit(6'd1, 5'd15, 5'd14, 5'd14, 32'h0, 1'b0, "R3 no update");
        drain("R3 vector untouched");

        // R8: fill the queues, then retire a load needing space
        for (int i = 0; i < IQD; i++)
            commit(6'd2, 5'(16 + i), 5'd9, 5'd0, 32'hA00 + 32'(i), 1'b1, "R8 fill");
        commit(6'd2, 5'd20, 5'd9, 5'd0, 32'hAFF, 1'b1, "R8 stall");
        commit(6'd1, 5'd21, 5'd22, 5'd23, 32'h0, 1'b0, "R8 filtered while full");
        commit(6'd5, 5'd21, 5'd16, 5'd16, 32'h0, 1'b1, "R8/R3 invalid while full");
        // R9: syscall held while queues hold entries
        commit(6'd4, 5'd0, 5'd0, 5'd0, 32'h0, 1'b0, "R9 held");
        drain("R8/R10 order");
        commit(6'd4, 5'd0, 5'd0, 5'd0, 32'h0, 1'b0, "R9 accepted");
        drain("R9 nothing emitted");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule